// File: doc/BRIEF.md
# Epoch-Pipelined Crossbar Wavefront Allocator

This block schedules a 15-port input-queued crossbar. Each input presents a request row with one bit for every output it holds at least one queued packet for. A packet stuck behind a blocked head can therefore still be scheduled. Time is cut into epochs of 16 cycles. In the first cycle of an epoch the allocator takes a snapshot of the request matrix. In the cycles that follow it sweeps the matrix one wrapped diagonal at a time, and a cell on a diagonal is granted when both its input and its output are still free. Once a cell is granted, every other cell in its row and column is passed over without being examined.

A finished matching is announced at the start of the next epoch. The block then carries it through a four-stage epoch pipeline, so that inputs, outputs and data-path slices have time to prepare. It drives the crossbar during the fourth epoch after the one in which its requests were sampled. The starting diagonal moves forward by one every epoch, so no fixed input–output pair is always favoured.

Top module: `xbar_wavefront_sched`

## Requirements
- R1: While reset is held and right after it is released, `announce`, `ann_gnt`, `gnt_row` and `src_vld` are all zero.
- R2: The request matrix is sampled only on the first clock edge of each epoch. Changes to `req` at any other time have no effect on that epoch's decision.
- R3: Every announced or active grant matrix holds at most one set bit per input row and at most one per output column.
- R4: Every grant bit is set only where the sampled request bit is set. Bit i*15+j of `req`, `ann_gnt` and `gnt_row` means input i to output j.
- R5: Each matching is maximal. For every requested cell, its input or its output already holds a grant.
- R6: Cells are visited by diagonal index (i+j) mod 15. The sweep starts at diagonal e mod 15, where e is the epoch count since reset starting from 0, and continues with increasing index, wrapping around. A cell on an earlier diagonal wins.
- R7: `announce` is high for exactly one cycle, the second cycle of every epoch. In that cycle `ann_gnt` shows the decision made from the requests sampled one epoch earlier.
- R8: The decision made from requests sampled at the start of epoch e is driven on `gnt_row` for all 16 cycles of epoch e+4, and not before.
- R9: For each output j, `src_vld[j]` is high exactly when some active grant targets j, and `src_sel[4*j +: 4]` then holds that input's index. Otherwise `src_sel[4*j +: 4]` is zero.
- R10: A full request matrix yields 15 simultaneous transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 225 | Request matrix, bit i*15+j: input i has traffic for output j |
| announce | output | 1 | One-cycle strobe marking a newly announced schedule |
| ann_gnt | output | 225 | Matching just decided, same layout as `req` |
| gnt_row | output | 225 | Matching in force for the current epoch, row i is input i's grant vector |
| src_sel | output | 60 | Per-output 4-bit index of the source input |
| src_vld | output | 15 | Per-output flag that a transfer is in force |

## Verification
The hardest behaviour to reach from the ports is the rotating priority. Which of two contending inputs wins depends only on the epoch count since reset. To reach it, the stimulus runs idle epochs until the count lands on a chosen starting diagonal, then offers a pair of requests that contend for one output. This is done at two adjacent counts, so the winner must flip. A separate case rewrites the request inputs in the middle of an epoch to show the snapshot is taken only once. Pseudo-random matrices are also compared exactly against a diagonal-order model and checked for conflict freedom, request coverage and maximality.

// File: rtl/xbar_wavefront_sched.sv
module xbar_wavefront_sched #(
  parameter int N     = 15,
  parameter int EPOCH = 16,
  parameter int LEAD  = 4,
  localparam int SW   = $clog2(N),
  localparam int NN   = N * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NN-1:0] req,
  output logic          announce,
  output logic [NN-1:0] ann_gnt,
  output logic [NN-1:0] gnt_row,
  output logic [N*SW-1:0] src_sel,
  output logic [N-1:0]  src_vld
);

  localparam int CW = $clog2(EPOCH);
  localparam logic [CW-1:0] LAST = CW'(EPOCH - 1);
  localparam logic [CW-1:0] NLIM = CW'(N);

  logic [CW-1:0] cnt;
  logic [SW-1:0] rot;
  logic [NN-1:0] req_q;
  logic [N-1:0]  rf, cf;
  logic [N-1:0]  mt   [N];
  logic [N-1:0]  pipe [LEAD][N];
  logic [SW-1:0] diag;
  logic [SW-1:0] col  [N];
  logic [N-1:0]  hit;
  logic          sweep;

  assign sweep = (cnt != '0) && (cnt <= NLIM);

  always_comb begin
    int dsum;
    dsum = int'(rot) + int'(cnt) - 1;
    if (dsum < 0) dsum = 0;
    if (dsum >= N) dsum = dsum - N;
    diag = SW'(dsum);
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int c;
      c = int'(diag) - i;
      if (c < 0) c = c + N;
      col[i] = SW'(c);
      hit[i] = sweep && rf[i] && cf[col[i]] && req_q[i*N + c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rot      <= '0;
      req_q    <= '0;
      rf       <= '0;
      cf       <= '0;
      announce <= 1'b0;
      for (int i = 0; i < N; i++) begin
        mt[i] <= '0;
        for (int s = 0; s < LEAD; s++) pipe[s][i] <= '0;
      end
    end else begin
      cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
      announce <= (cnt == '0);
      if (cnt == LAST) rot <= (rot == SW'(N - 1)) ? '0 : rot + 1'b1;
      if (cnt == '0) begin
        req_q <= req;
        rf    <= '1;
        cf    <= '1;
        for (int i = 0; i < N; i++) begin
          pipe[0][i] <= mt[i];
          for (int s = 1; s < LEAD; s++) pipe[s][i] <= pipe[s-1][i];
          mt[i] <= '0;
        end
      end else begin
        for (int i = 0; i < N; i++) begin
          if (hit[i]) begin
            mt[i][col[i]] <= 1'b1;
            rf[i]         <= 1'b0;
            cf[col[i]]    <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign ann_gnt[i*N +: N] = pipe[0][i];
    assign gnt_row[i*N +: N] = pipe[LEAD-1][i];
  end

  always_comb begin
    src_vld = '0;
    src_sel = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if (pipe[LEAD-1][i][j]) begin
          src_vld[j]          = 1'b1;
          src_sel[j*SW +: SW] = SW'(i);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_wavefront_chk.sv
module xbar_wavefront_chk #(
  parameter int N     = 15,
  parameter int EPOCH = 16,
  parameter int SW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*N-1:0]  req_q,
  input logic            announce,
  input logic [N*N-1:0]  ann_gnt,
  input logic [N*N-1:0]  gnt_row,
  input logic [N*SW-1:0] src_sel,
  input logic [N-1:0]    src_vld
);

  localparam int CW = $clog2(EPOCH);

  logic [CW-1:0]  k;
  logic [N*N-1:0] prev_req;
  logic [N-1:0]   ann_cols [N];
  logic [N-1:0]   act_cols [N];
  logic [N-1:0]   ann_r, ann_c, act_c;
  logic ann_row_bad, ann_col_bad, act_row_bad, act_col_bad, gap, sel_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k        <= '0;
      prev_req <= '0;
    end else begin
      k        <= (k == CW'(EPOCH - 1)) ? '0 : k + 1'b1;
      prev_req <= req_q;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_row
      assign ann_cols[j][i] = ann_gnt[i*N + j];
      assign act_cols[j][i] = gnt_row[i*N + j];
    end
  end

  always_comb begin
    ann_row_bad = 1'b0;
    ann_col_bad = 1'b0;
    act_row_bad = 1'b0;
    act_col_bad = 1'b0;
    gap         = 1'b0;
    sel_bad     = 1'b0;
    for (int i = 0; i < N; i++) begin
      ann_r[i] = |ann_gnt[i*N +: N];
      ann_c[i] = |ann_cols[i];
      act_c[i] = |act_cols[i];
      if ($countones(ann_gnt[i*N +: N]) > 1) ann_row_bad = 1'b1;
      if ($countones(gnt_row[i*N +: N]) > 1) act_row_bad = 1'b1;
      if ($countones(ann_cols[i]) > 1)       ann_col_bad = 1'b1;
      if ($countones(act_cols[i]) > 1)       act_col_bad = 1'b1;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (prev_req[i*N + j] && !ann_r[i] && !ann_c[j]) gap = 1'b1;
    for (int j = 0; j < N; j++) begin
      if (src_vld[j]) begin
        if (int'(src_sel[j*SW +: SW]) >= N) sel_bad = 1'b1;
        else if (!gnt_row[int'(src_sel[j*SW +: SW])*N + j]) sel_bad = 1'b1;
      end else if (src_sel[j*SW +: SW] != '0) sel_bad = 1'b1;
    end
  end

  p_snapshot_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (k != '0) |=> $stable(req_q));
  p_ann_rows_r3: assert property (@(posedge clk) disable iff (!rst_n) !ann_row_bad);
  p_ann_cols_r3: assert property (@(posedge clk) disable iff (!rst_n) !ann_col_bad);
  p_act_rows_r3: assert property (@(posedge clk) disable iff (!rst_n) !act_row_bad);
  p_act_cols_r3: assert property (@(posedge clk) disable iff (!rst_n) !act_col_bad);
  p_grant_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    announce |-> ((ann_gnt & ~prev_req) == '0));
  p_maximal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    announce |-> !gap);
  p_announce_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    announce == (k == CW'(1)));
  p_hold_epoch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (k != '0) |=> $stable(gnt_row));
  p_src_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld == act_c);
  p_src_sel_r9: assert property (@(posedge clk) disable iff (!rst_n) !sel_bad);
  p_full_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (announce && (&prev_req)) |-> ($countones(ann_gnt) == N));

endmodule

bind xbar_wavefront_sched xbar_wavefront_chk #(.N(N), .EPOCH(EPOCH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_q(req_q), .announce(announce),
  .ann_gnt(ann_gnt), .gnt_row(gnt_row), .src_sel(src_sel), .src_vld(src_vld)
);

// File: tb/sim_xbar_wavefront_sched.sv
module sim_xbar_wavefront_sched;
  localparam int N  = 15;
  localparam int NN = N * N;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NN-1:0] req = '0;
  logic announce;
  logic [NN-1:0] ann_gnt, gnt_row;
  logic [N*SW-1:0] src_sel;
  logic [N-1:0] src_vld;

  int errors = 0;
  int checks = 0;
  int ep = 0;
  bit done = 1'b0;

  logic s_ann, s_ann2;
  logic [NN-1:0] s_anng, s_gnt, s_gnt_last;
  logic [N*SW-1:0] s_sel;
  logic [N-1:0] s_vld;

  always #5 clk = ~clk;

  xbar_wavefront_sched u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .announce(announce),
    .ann_gnt(ann_gnt), .gnt_row(gnt_row), .src_sel(src_sel), .src_vld(src_vld)
  );

  task automatic chk(input bit ok, input string tag, input logic [NN-1:0] act,
                     input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NN-1:0] model(input logic [NN-1:0] r, input int rot);
    logic [NN-1:0] m;
    logic [N-1:0] rf, cf;
    m = '0; rf = '1; cf = '1;
    for (int k = 0; k < N; k++) begin
      int d;
      d = (rot + k) % N;
      for (int i = 0; i < N; i++) begin
        int j;
        j = (d + N - i) % N;
        if (r[i*N + j] && rf[i] && cf[j]) begin
          m[i*N + j] = 1'b1; rf[i] = 1'b0; cf[j] = 1'b0;
        end
      end
    end
    return m;
  endfunction

  function automatic bit conflict_free(input logic [NN-1:0] m);
    for (int a = 0; a < N; a++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int b = 0; b < N; b++) begin
        rc += m[a*N + b];
        cc += m[b*N + a];
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit maximal(input logic [NN-1:0] m, input logic [NN-1:0] r);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N + j] && !(|m[i*N +: N])) begin
          bit cused;
          cused = 1'b0;
          for (int x = 0; x < N; x++) cused |= m[x*N + j];
          if (!cused) return 1'b0;
        end
    return 1'b1;
  endfunction

  task automatic do_epoch(input logic [NN-1:0] p, input logic [NN-1:0] mid, input bit use_mid);
    req = p;
    @(posedge clk); @(negedge clk);
    s_ann = announce; s_anng = ann_gnt; s_gnt = gnt_row; s_sel = src_sel; s_vld = src_vld;
    @(posedge clk); @(negedge clk);
    s_ann2 = announce;
    if (use_mid) req = mid;
    repeat (14) @(posedge clk);
    @(negedge clk);
    s_gnt_last = gnt_row;
    ep++;
  endtask

  task automatic align_rot(input int t);
    while (ep % N != t) do_epoch('0, '0, 1'b0);
  endtask

  task automatic run_case(input logic [NN-1:0] p, input logic [NN-1:0] q, input bit use_mid,
                          output logic [NN-1:0] got);
    logic [NN-1:0] exp;
    logic [N*SW-1:0] esel;
    logic [N-1:0] evld;
    exp = model(p, ep % N);
    do_epoch(p, q, use_mid);
    do_epoch('0, '0, 1'b0);
    got = s_anng;
    chk(s_ann == 1'b1, "R7 announce in second cycle", NN'(s_ann), NN'(1));
    chk(s_ann2 == 1'b0, "R7 announce one cycle only", NN'(s_ann2), NN'(0));
    chk(s_anng == exp, "R6 diagonal order / R2 snapshot", s_anng, exp);
    chk(conflict_free(s_anng), "R3 one per row and column", s_anng, exp);
    chk((s_anng & ~p) == '0, "R4 grant has request", s_anng & ~p, '0);
    chk(maximal(s_anng, p), "R5 maximal matching", s_anng, p);
    do_epoch('0, '0, 1'b0);
    do_epoch('0, '0, 1'b0);
    chk(s_gnt == '0 && s_gnt_last == '0, "R8 not active early", s_gnt | s_gnt_last, '0);
    do_epoch('0, '0, 1'b0);
    chk(s_gnt == exp, "R8 active at epoch plus four", s_gnt, exp);
    chk(s_gnt_last == exp, "R8 held for whole epoch", s_gnt_last, exp);
    esel = '0; evld = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (exp[i*N + j]) begin evld[j] = 1'b1; esel[j*SW +: SW] = SW'(i); end
    chk(s_vld == evld, "R9 source valid", NN'(s_vld), NN'(evld));
    chk(s_sel == esel, "R9 source select", NN'(s_sel), NN'(esel));
  endtask

  task automatic t_reset;
    chk(announce == 1'b0 && src_vld == '0, "R1 reset strobe and valid",
        NN'({announce, src_vld}), '0);
    chk(ann_gnt == '0 && gnt_row == '0, "R1 reset grants", ann_gnt | gnt_row, '0);
  endtask

  task automatic t_single;
    logic [NN-1:0] p, g;
    p = '0; p[3*N + 7] = 1'b1;
    run_case(p, '0, 1'b0, g);
    chk(g == p, "R4 single request granted", g, p);
  endtask

  task automatic t_hol;
    logic [NN-1:0] p, g, e;
    p = '0; p[0*N + 0] = 1'b1; p[0*N + 5] = 1'b1; p[1*N + 0] = 1'b1;
    align_rot(0);
    run_case(p, '0, 1'b0, g);
    e = '0; e[0*N + 0] = 1'b1;
    chk(g == e, "R6 rot0 favours diagonal 0", g, e);
    align_rot(1);
    run_case(p, '0, 1'b0, g);
    e = '0; e[0*N + 5] = 1'b1; e[1*N + 0] = 1'b1;
    chk(g == e, "R5 queued packet behind head sent", g, e);
  endtask

  task automatic t_rotate;
    logic [NN-1:0] p, g, e;
    p = '0; p[0*N + 2] = 1'b1; p[1*N + 2] = 1'b1;
    align_rot(2);
    run_case(p, '0, 1'b0, g);
    e = '0; e[0*N + 2] = 1'b1;
    chk(g == e, "R6 rot2 input 0 wins", g, e);
    align_rot(3);
    run_case(p, '0, 1'b0, g);
    e = '0; e[1*N + 2] = 1'b1;
    chk(g == e, "R6 rot3 input 1 wins", g, e);
  endtask

  task automatic t_mid_change;
    logic [NN-1:0] p, q, g;
    p = '0; p[4*N + 9] = 1'b1;
    q = '0; q[4*N + 1] = 1'b1; q[6*N + 6] = 1'b1;
    run_case(p, q, 1'b1, g);
    chk(g == p, "R2 mid-epoch change ignored", g, p);
  endtask

  task automatic t_full;
    logic [NN-1:0] g;
    run_case('1, '0, 1'b0, g);
    chk($countones(g) == N, "R10 full load gives 15 transfers", NN'($countones(g)), NN'(N));
  endtask

  task automatic t_random(input int n, input int dens);
    for (int c = 0; c < n; c++) begin
      logic [NN-1:0] p, g;
      for (int b = 0; b < NN; b++) p[b] = (($urandom % 16) < dens);
      run_case(p, '0, 1'b0, g);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_hol();
    t_rotate();
    t_mid_change();
    t_full();
    t_random(10, 2);
    t_random(10, 8);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", '0, '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule